// File: doc/BRIEF.md
# Supervisor Trap Controller

This block is the supervisor-level trap state machine of a small 32-bit core. It holds the global interrupt enable, the saved enable and the saved privilege bit of the status word. It also holds the trap cause and the trap PC registers, and one enable bit and one pending bit for the supervisor timer interrupt. The pipeline feeds it three kinds of request: a synchronous exception with a cause code and the faulting PC, the asynchronous timer line, and a return-from-trap (SRET) request.

In the same cycle as a request, the block drives a redirect strobe and the target PC. For a trap the target is the fixed vector base input. For a return it is the saved trap PC. The status, cause and trap-PC registers update on the following clock edge. The current privilege level is always visible on an output. Exceptions are never masked. The timer interrupt passes through the global enable and its own enable, and it can be parked as pending until its enable is set.

Top module: `s_trap_ctrl`

## Requirements
- R1: An exception request is taken in its own cycle whatever the global enable is. The redirect strobe goes high with the PC equal to the vector base. After the edge, the cause register holds the request code with bit 31 at 0, and the trap PC register holds the faulting PC.
- R2: On any trap entry, the saved enable takes the old global enable, the global enable clears, and privilege becomes supervisor (priv_o = 2'b01).
- R3: On trap entry, the saved privilege bit becomes 1 if the trap came from supervisor mode and 0 if it came from user mode (priv_o = 2'b00).
- R4: A taken timer interrupt writes the cause register with 0x8000_0005 (bit 31 set, code 5) and the trap PC register with pc_i.
- R5: While the global enable is 0, the timer line has no effect: no redirect, and the pending bit is unchanged.
- R6: A timer request that arrives while the global enable is 1 and the timer enable is 0 takes no trap and sets the pending bit.
- R7: A pending timer bit is taken as an interrupt in the first cycle in which both the timer enable and the global enable read 1. Taking it clears the pending bit.
- R8: SRET sets the global enable and the saved enable to 1, clears the saved privilege bit, and redirects in the same cycle to the saved trap PC.
- R9: SRET sets privilege to user if the saved privilege bit was 0, and to supervisor if it was 1.
- R10: Priority is exception, then timer interrupt, then SRET. A lower-priority request in the same cycle has no effect.
- R11: After reset, privilege is supervisor, all status, enable and pending bits are 0, the cause and trap PC registers are 0, and there is no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 31 | Exception cause code |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| tmr_irq_i | input | 1 | Supervisor timer interrupt line |
| sret_i | input | 1 | Return-from-trap request |
| pc_i | input | 32 | PC of the instruction an interrupt preempts |
| tvec_i | input | 32 | Fixed trap vector base |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wd_i | input | 1 | Global enable write data |
| tmr_en_we_i | input | 1 | Write strobe for the timer enable |
| tmr_en_wd_i | input | 1 | Timer enable write data |
| redirect_o | output | 1 | PC redirect strobe, same cycle as the request |
| redirect_pc_o | output | 32 | Redirect target |
| priv_o | output | 2 | Current privilege: 00 user, 01 supervisor |
| gie_o | output | 1 | Global interrupt enable |
| prev_ie_o | output | 1 | Saved interrupt enable |
| prev_priv_o | output | 1 | Saved privilege bit |
| scause_o | output | 32 | Trap cause register |
| sepc_o | output | 32 | Trap PC register |
| tmr_en_o | output | 1 | Timer interrupt enable |
| tmr_pend_o | output | 1 | Timer interrupt pending |

## Verification
The hardest state to reach is a pending timer bit that is later taken. First the global enable must be 1 while the timer enable is 0 and the line pulses. Then the enable is written, and the bench watches for a trap on the following idle cycle. The vector table builds this sequence step by step. It also walks the privilege bit through supervisor-to-supervisor and supervisor-to-user returns, so that user-mode trap entry can be checked. Collisions (exception with timer, exception with SRET) are driven in single cycles once the state leaves the lower-priority request armed.

// File: rtl/s_trap_pkg.sv
package s_trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01
  } priv_e;
endpackage

// File: rtl/s_trap_irq.sv
module s_trap_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmr_irq_i,
  input  logic gie_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  input  logic take_i,
  output logic req_o,
  output logic en_o,
  output logic pend_o
);
  logic en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wd_i;
      if (take_i) pend_q <= 1'b0;
      else if (tmr_irq_i && gie_i && !en_q) pend_q <= 1'b1;
    end
  end

  assign req_o  = gie_i & en_q & (tmr_irq_i | pend_q);
  assign en_o   = en_q;
  assign pend_o = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_irq_i && gie_i && !en_q |=> pend_q); // R6
  AST_PEND_HOLD_NO_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i && !take_i |=> pend_q == $past(pend_q)); // R5
  AST_TAKE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !pend_q); // R7
endmodule

// File: rtl/s_trap_status.sv
module s_trap_status
  import s_trap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_i,
  input  logic       ret_i,
  input  logic       gie_we_i,
  input  logic       gie_wd_i,
  output logic       gie_o,
  output logic       prev_ie_o,
  output logic       prev_priv_o,
  output logic [1:0] priv_o
);
  logic  gie_q, pie_q, ppriv_q;
  priv_e priv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      pie_q   <= 1'b0;
      ppriv_q <= 1'b0;
      priv_q  <= PRIV_S;
    end else if (trap_i) begin
      pie_q   <= gie_q;
      gie_q   <= 1'b0;
      ppriv_q <= (priv_q == PRIV_S);
      priv_q  <= PRIV_S;
    end else if (ret_i) begin
      gie_q   <= 1'b1;
      pie_q   <= 1'b1;
      ppriv_q <= 1'b0;
      priv_q  <= ppriv_q ? PRIV_S : PRIV_U;
    end else if (gie_we_i) begin
      gie_q <= gie_wd_i;
    end
  end

  assign gie_o       = gie_q;
  assign prev_ie_o   = pie_q;
  assign prev_priv_o = ppriv_q;
  assign priv_o      = priv_q;

  AST_TRAP_GIE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !gie_q && pie_q == $past(gie_q) && priv_q == PRIV_S); // R2
  AST_TRAP_PPRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> ppriv_q == ($past(priv_q) == PRIV_S)); // R3
  AST_RET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !trap_i |=> gie_q && pie_q && !ppriv_q); // R8
  AST_RET_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !trap_i |=> priv_q == ($past(ppriv_q) ? PRIV_S : PRIV_U)); // R9
endmodule

// File: rtl/s_trap_csr.sv
module s_trap_csr #(
  parameter int XLEN      = 32,
  parameter int TMR_CAUSE = 5,
  localparam int CAUSE_W  = XLEN - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [XLEN-1:0]    pc_i,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o
);
  logic [XLEN-1:0] scause_q, sepc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scause_q <= '0;
      sepc_q   <= '0;
    end else if (trap_i) begin
      scause_q <= irq_i ? {1'b1, CAUSE_W'(TMR_CAUSE)} : {1'b0, cause_i};
      sepc_q   <= irq_i ? pc_i : epc_i;
    end
  end

  assign scause_o = scause_q;
  assign sepc_o   = sepc_q;

  AST_EXC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && !irq_i |=> !scause_q[XLEN-1] && sepc_q == $past(epc_i)); // R1
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && irq_i |=> scause_q[XLEN-1] && sepc_q == $past(pc_i)); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_i |=> $stable(scause_q) && $stable(sepc_q)); // R10
endmodule

// File: rtl/s_trap_ctrl.sv
module s_trap_ctrl
  import s_trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int TMR_CAUSE = 5,
  localparam int CAUSE_W  = XLEN - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_valid_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic               tmr_irq_i,
  input  logic               sret_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               gie_we_i,
  input  logic               gie_wd_i,
  input  logic               tmr_en_we_i,
  input  logic               tmr_en_wd_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         priv_o,
  output logic               gie_o,
  output logic               prev_ie_o,
  output logic               prev_priv_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic               tmr_en_o,
  output logic               tmr_pend_o
);
  logic irq_req, irq_take, trap, ret_take, gie;

  // exception > interrupt > return
  assign irq_take = irq_req & ~exc_valid_i;
  assign trap     = exc_valid_i | irq_req;
  assign ret_take = sret_i & ~trap;

  s_trap_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmr_irq_i (tmr_irq_i),
    .gie_i     (gie),
    .en_we_i   (tmr_en_we_i),
    .en_wd_i   (tmr_en_wd_i),
    .take_i    (irq_take),
    .req_o     (irq_req),
    .en_o      (tmr_en_o),
    .pend_o    (tmr_pend_o)
  );

  s_trap_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trap_i      (trap),
    .ret_i       (ret_take),
    .gie_we_i    (gie_we_i),
    .gie_wd_i    (gie_wd_i),
    .gie_o       (gie),
    .prev_ie_o   (prev_ie_o),
    .prev_priv_o (prev_priv_o),
    .priv_o      (priv_o)
  );

  s_trap_csr #(.XLEN(XLEN), .TMR_CAUSE(TMR_CAUSE)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trap_i   (trap),
    .irq_i    (irq_take),
    .cause_i  (exc_cause_i),
    .epc_i    (exc_pc_i),
    .pc_i     (pc_i),
    .scause_o (scause_o),
    .sepc_o   (sepc_o)
  );

  assign gie_o         = gie;
  assign redirect_o    = trap | ret_take;
  assign redirect_pc_o = ret_take ? sepc_o : tvec_i;

  AST_EXC_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> redirect_o && redirect_pc_o == tvec_i); // R1
  AST_NO_IRQ_WO_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o && !exc_valid_i && !sret_i |-> !redirect_o); // R5
  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && !exc_valid_i && !(gie_o && tmr_en_o && (tmr_irq_i || tmr_pend_o))
      |-> redirect_o && redirect_pc_o == sepc_o); // R8
  AST_EXC_BEATS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> !scause_o[XLEN-1]); // R10
endmodule

// File: tb/s_trap_ctrl_test.sv
module s_trap_ctrl_test;
  localparam logic [31:0] TV = 32'h8000_0100;
  localparam logic [1:0]  PS = 2'b01;
  localparam logic [1:0]  PU = 2'b00;

  typedef struct packed {
    logic        exc;
    logic [7:0]  cause;
    logic [31:0] epc;
    logic        tmr;
    logic        sret;
    logic        gwe;
    logic        gwd;
    logic        twe;
    logic        twd;
    logic [31:0] pc;
    logic        e_red;
    logic [31:0] e_rpc;
    logic [1:0]  e_priv;
    logic        e_gie;
    logic        e_pie;
    logic        e_pp;
    logic [31:0] e_cause;
    logic [31:0] e_sepc;
    logic        e_pend;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{0, 8'd0,  32'h0,    0,0,1,1,0,0, 32'h0,    0,32'h0,    PS,1,0,0,32'h0,        32'h0,    0}, // gie on
    '{0, 8'd0,  32'h0,    1,0,0,0,0,0, 32'h0,    0,32'h0,    PS,1,0,0,32'h0,        32'h0,    1}, // R6
    '{0, 8'd0,  32'h0,    0,0,0,0,1,1, 32'h0,    0,32'h0,    PS,1,0,0,32'h0,        32'h0,    1}, // enable written
    '{0, 8'd0,  32'h0,    0,0,0,0,0,0, 32'h1000, 1,TV,       PS,0,1,1,32'h8000_0005,32'h1000, 0}, // R7 R4
    '{0, 8'd0,  32'h0,    0,1,0,0,0,0, 32'h0,    1,32'h1000, PS,1,1,0,32'h8000_0005,32'h1000, 0}, // R8 R9
    '{1, 8'd2,  32'h2000, 0,0,0,0,0,0, 32'h0,    1,TV,       PS,0,1,1,32'h2,        32'h2000, 0}, // R1 R3
    '{0, 8'd0,  32'h0,    0,1,0,0,0,0, 32'h0,    1,32'h2000, PS,1,1,0,32'h2,        32'h2000, 0}, // R9 S
    '{0, 8'd0,  32'h0,    0,1,0,0,0,0, 32'h0,    1,32'h2000, PU,1,1,0,32'h2,        32'h2000, 0}, // R9 U
    '{1, 8'd8,  32'h3000, 0,0,0,0,0,0, 32'h0,    1,TV,       PS,0,1,0,32'h8,        32'h3000, 0}, // R3 from U
    '{0, 8'd0,  32'h0,    1,0,0,0,0,0, 32'h0,    0,32'h0,    PS,0,1,0,32'h8,        32'h3000, 0}, // R5
    '{0, 8'd0,  32'h0,    0,1,0,0,0,0, 32'h0,    1,32'h3000, PU,1,1,0,32'h8,        32'h3000, 0}, // R9
    '{1, 8'd13, 32'h4000, 1,0,0,0,0,0, 32'h5000, 1,TV,       PS,0,1,0,32'hd,        32'h4000, 0}, // R10
    '{0, 8'd0,  32'h0,    0,1,0,0,0,0, 32'h0,    1,32'h4000, PU,1,1,0,32'hd,        32'h4000, 0}, // R8
    '{0, 8'd0,  32'h0,    1,0,0,0,0,0, 32'h6000, 1,TV,       PS,0,1,0,32'h8000_0005,32'h6000, 0}, // R4 from U
    '{1, 8'd3,  32'h7000, 0,0,0,0,0,0, 32'h0,    1,TV,       PS,0,0,1,32'h3,        32'h7000, 0}  // R1 masked
  };

  logic clk = 0, rst_n = 0;
  logic exc = 0, tmr = 0, sret = 0, gwe = 0, gwd = 0, twe = 0, twd = 0;
  logic [30:0] cause = '0;
  logic [31:0] epc = '0, pc = '0;
  logic red, gie, pie, pp, ten, pend;
  logic [31:0] rpc, scause, sepc;
  logic [1:0] priv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  s_trap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc), .exc_cause_i(cause),
    .exc_pc_i(epc), .tmr_irq_i(tmr), .sret_i(sret), .pc_i(pc), .tvec_i(TV),
    .gie_we_i(gwe), .gie_wd_i(gwd), .tmr_en_we_i(twe), .tmr_en_wd_i(twd),
    .redirect_o(red), .redirect_pc_o(rpc), .priv_o(priv), .gie_o(gie),
    .prev_ie_o(pie), .prev_priv_o(pp), .scause_o(scause), .sepc_o(sepc),
    .tmr_en_o(ten), .tmr_pend_o(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    exc = v.exc; cause = 31'(v.cause); epc = v.epc; tmr = v.tmr; sret = v.sret;
    gwe = v.gwe; gwd = v.gwd; twe = v.twe; twd = v.twd; pc = v.pc;
  endtask

  task automatic check_state(input string req, input vec_t v);
    chk({req, " priv"},   32'(priv),   32'(v.e_priv));
    chk({req, " gie"},    32'(gie),    32'(v.e_gie));
    chk({req, " pie"},    32'(pie),    32'(v.e_pie));
    chk({req, " ppriv"},  32'(pp),     32'(v.e_pp));
    chk({req, " scause"}, scause,      v.e_cause);
    chk({req, " sepc"},   sepc,        v.e_sepc);
    chk({req, " pend"},   32'(pend),   32'(v.e_pend));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 redirect", 32'(red), 0);
    chk("R11 priv", 32'(priv), 32'(PS));
    chk("R11 gie", 32'(gie), 0);
    chk("R11 pie", 32'(pie), 0);
    chk("R11 ppriv", 32'(pp), 0);
    chk("R11 scause", scause, 0);
    chk("R11 sepc", sepc, 0);
    chk("R11 pend", 32'(pend), 0);
    chk("R11 ten", 32'(ten), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      chk($sformatf("R1/R8/R10 v%0d redirect", i), 32'(red), 32'(VEC[i].e_red));
      if (VEC[i].e_red) chk($sformatf("R1/R8 v%0d target", i), rpc, VEC[i].e_rpc);
      @(posedge clk);
      #1;
      check_state($sformatf("R2/R3/R4/R9 v%0d", i), VEC[i]);
    end

    // R10: exception and SRET together, exception wins (state: S, gie 0, ppriv 1)
    @(negedge clk);
    d = '0; d.exc = 1; d.cause = 8'd4; d.epc = 32'h8000; d.sret = 1;
    drive(d);
    #1;
    chk("R10 exc+sret target", rpc, TV);
    @(posedge clk);
    #1;
    chk("R10 exc+sret gie", 32'(gie), 0);
    chk("R10 exc+sret cause", scause, 32'h4);
    chk("R10 exc+sret ppriv", 32'(pp), 1);
    chk("R10 exc+sret priv", 32'(priv), 32'(PS));

    // R5: timer with gie 0 and enable cleared leaves pending at 0
    @(negedge clk);
    d = '0; d.twe = 1; d.twd = 0;
    drive(d);
    @(negedge clk);
    d = '0; d.tmr = 1;
    drive(d);
    #1;
    chk("R5 no redirect", 32'(red), 0);
    @(posedge clk);
    #1;
    chk("R5 pend unchanged", 32'(pend), 0);

    // R11: reset mid-run
    @(negedge clk);
    drive('0);
    rst_n = 0;
    #1;
    chk("R11 rerst priv", 32'(priv), 32'(PS));
    chk("R11 rerst scause", scause, 0);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule